// File: doc/BRIEF.md
# Programmable Delay-Line Controller

This block drives the four active-low control pins of a fixed-depth, wrapping line buffer: write-pointer reset, read-pointer reset, write enable and read enable. It sequences them so that a word written on one clock comes back out exactly N clocks later. N is supplied at run time on `delay_len`, and a one-cycle `start` pulse begins a new sequence. The block counts clocks itself and times every strobe from that count. The buffer storage and any line timing beyond this word counter are outside the block.

Three pointer strategies are available on `mode`. Periodic mode (code 0) pulses both pointer resets together every N clocks, so the buffer only cycles through addresses 0..N-1. Staggered mode (code 1) resets the write pointer first and the read pointer N clocks later, and then lets both pointers run free. Hold mode (code 2) resets both pointers together and keeps the read pointer from advancing for N clocks. Code 3 is reserved. The buffer cannot return data written fewer than 21 words earlier and holds at most DEPTH words. A request outside that range, or one with the reserved mode, raises `err` and leaves every control pin inactive.

There is no data stream through this block, so all of its pins are plain control and status lines and none of them uses a handshake. Outputs are registered. Cycle 0 is the cycle that follows the clock edge at which `start` was sampled high.

Top module: `dlc_delay_ctrl`

## Requirements
- R1: After reset, wr_rst_n, rd_rst_n, wr_en_n and rd_en_n are all high (inactive), and err and locked are 0.
- R2: A start with delay_len below MIN_DELAY (21), delay_len above DEPTH (5120), or mode code 3 sets err to 1 from cycle 0. It drives all four control pins high and locked to 0 until the next valid start. A valid start clears err in its cycle 0.
- R3: Every pointer-reset strobe is a low pulse exactly one cycle wide.
- R4: In periodic mode (code 0), wr_rst_n and rd_rst_n are low together in cycle 0 and in every cycle that is a multiple of N. Both enables are low from cycle 0.
- R5: In staggered mode (code 1), wr_rst_n is low only in cycle 0 and rd_rst_n is low only in cycle N. Both enables are low from cycle 0.
- R6: In hold mode (code 2), both reset strobes are low only in cycle 0. wr_en_n is low from cycle 0. rd_en_n stays high in cycles 0..N-1 and is low from cycle N on.
- R7: In every mode, locked is 0 in cycles 0..N-1 and 1 from cycle N until the next start.
- R8: A valid start that arrives while a sequence is already running abandons that sequence. The new mode and length take effect from a fresh cycle 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a sequence |
| mode | input | 2 | Strategy: 0 periodic, 1 staggered, 2 hold, 3 reserved |
| delay_len | input | LEN_W | Requested delay N in words |
| wr_rst_n | output | 1 | Write-pointer reset strobe, active low |
| rd_rst_n | output | 1 | Read-pointer reset strobe, active low |
| wr_en_n | output | 1 | Write-pointer increment enable, active low |
| rd_en_n | output | 1 | Read-pointer increment enable, active low |
| err | output | 1 | Last request was rejected |
| locked | output | 1 | Programmed offset is established |

## Verification
The bench builds the block with its default parameters: DEPTH 5120, MIN_DELAY 21, and hence a 13-bit length port. These defaults allow exact tests at both edges of the valid range, 21 and 5120. They also allow tests just outside it, at 20 and 5121, because 5121 still fits in the port. Since the full-depth case needs only about ten thousand cycles, the bench follows every mode through two complete periods, including at maximum length, and also covers mid-sequence restarts and rejected requests that interrupt a running sequence.

// File: rtl/dlc_pkg.sv
package dlc_pkg;

  typedef enum logic [1:0] {
    MODE_PERIODIC = 2'd0,
    MODE_STAGGER  = 2'd1,
    MODE_HOLD     = 2'd2,
    MODE_RSVD     = 2'd3
  } dlc_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_LOCK = 2'd2
  } dlc_state_e;

  // Active-high internal view of the four buffer controls.
  typedef struct packed {
    logic wr_rst;
    logic rd_rst;
    logic wr_en;
    logic rd_en;
  } dlc_strb_t;

endpackage

// File: rtl/dlc_req_check.sv
module dlc_req_check #(
  parameter int DEPTH     = 5120,
  parameter int MIN_DELAY = 21,
  parameter int LEN_W     = 13
) (
  input  logic [1:0]       mode,
  input  logic [LEN_W-1:0] delay_len,
  output logic             req_ok
);
  import dlc_pkg::*;

  localparam logic [LEN_W-1:0] LO = LEN_W'(MIN_DELAY);
  localparam logic [LEN_W-1:0] HI = LEN_W'(DEPTH);

  logic len_ok;
  logic mode_ok;

  always_comb begin
    len_ok  = (delay_len >= LO) && (delay_len <= HI);
    mode_ok = (dlc_mode_e'(mode) != MODE_RSVD);
    req_ok  = len_ok && mode_ok;
  end

endmodule

// File: rtl/dlc_phase_cnt.sv
module dlc_phase_cnt #(
  parameter int LEN_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic             wrap,
  input  logic [LEN_W-1:0] period,
  output logic             hit
);

  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] last;

  always_comb begin
    last = period - LEN_W'(1);
    hit  = (cnt_q == last);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (run) begin
      if (hit) begin
        if (wrap) cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + LEN_W'(1);
      end
    end
  end

endmodule

// File: rtl/dlc_sequencer.sv
module dlc_sequencer (
  input  logic                  start,
  input  logic                  req_ok,
  input  dlc_pkg::dlc_mode_e    mode_in,
  input  dlc_pkg::dlc_mode_e    mode_q,
  input  dlc_pkg::dlc_state_e   state_q,
  input  dlc_pkg::dlc_strb_t    strb_q,
  input  logic                  err_q,
  input  logic                  locked_q,
  input  logic                  hit,
  output dlc_pkg::dlc_state_e   state_d,
  output dlc_pkg::dlc_strb_t    strb_d,
  output logic                  err_d,
  output logic                  locked_d,
  output logic                  cnt_run,
  output logic                  cnt_wrap
);
  import dlc_pkg::*;

  always_comb begin
    state_d       = state_q;
    err_d         = err_q;
    locked_d      = locked_q;
    strb_d.wr_rst = 1'b0;
    strb_d.rd_rst = 1'b0;
    strb_d.wr_en  = strb_q.wr_en;
    strb_d.rd_en  = strb_q.rd_en;

    if (start) begin
      locked_d = 1'b0;
      if (req_ok) begin
        state_d       = ST_ARM;
        err_d         = 1'b0;
        strb_d.wr_rst = 1'b1;
        strb_d.rd_rst = (mode_in != MODE_STAGGER);
        strb_d.wr_en  = 1'b1;
        strb_d.rd_en  = (mode_in != MODE_HOLD);
      end else begin
        state_d      = ST_IDLE;
        err_d        = 1'b1;
        strb_d.wr_en = 1'b0;
        strb_d.rd_en = 1'b0;
      end
    end else begin
      unique case (state_q)
        ST_ARM: begin
          if (hit) begin
            state_d  = ST_LOCK;
            locked_d = 1'b1;
            unique case (mode_q)
              MODE_PERIODIC: begin
                strb_d.wr_rst = 1'b1;
                strb_d.rd_rst = 1'b1;
              end
              MODE_STAGGER: strb_d.rd_rst = 1'b1;
              MODE_HOLD:    strb_d.rd_en  = 1'b1;
              default: ;
            endcase
          end
        end
        ST_LOCK: begin
          if (hit && (mode_q == MODE_PERIODIC)) begin
            strb_d.wr_rst = 1'b1;
            strb_d.rd_rst = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    cnt_wrap = (mode_q == MODE_PERIODIC);
    cnt_run  = (state_q == ST_ARM) || ((state_q == ST_LOCK) && cnt_wrap);
  end

endmodule

// File: rtl/dlc_delay_ctrl.sv
module dlc_delay_ctrl #(
  parameter int DEPTH     = 5120,
  parameter int MIN_DELAY = 21,
  parameter int LEN_W     = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       mode,
  input  logic [LEN_W-1:0] delay_len,
  output logic             wr_rst_n,
  output logic             rd_rst_n,
  output logic             wr_en_n,
  output logic             rd_en_n,
  output logic             err,
  output logic             locked
);
  import dlc_pkg::*;

  dlc_state_e       state_q, state_d;
  dlc_mode_e        mode_q;
  dlc_strb_t        strb_q, strb_d;
  logic [LEN_W-1:0] len_q;
  logic             err_q, err_d;
  logic             locked_q, locked_d;
  logic             req_ok;
  logic             hit;
  logic             cnt_run, cnt_wrap;

  dlc_req_check #(
    .DEPTH     (DEPTH),
    .MIN_DELAY (MIN_DELAY),
    .LEN_W     (LEN_W)
  ) u_check (
    .mode      (mode),
    .delay_len (delay_len),
    .req_ok    (req_ok)
  );

  dlc_phase_cnt #(
    .LEN_W (LEN_W)
  ) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (start),
    .run    (cnt_run),
    .wrap   (cnt_wrap),
    .period (len_q),
    .hit    (hit)
  );

  dlc_sequencer u_seq (
    .start    (start),
    .req_ok   (req_ok),
    .mode_in  (dlc_mode_e'(mode)),
    .mode_q   (mode_q),
    .state_q  (state_q),
    .strb_q   (strb_q),
    .err_q    (err_q),
    .locked_q (locked_q),
    .hit      (hit),
    .state_d  (state_d),
    .strb_d   (strb_d),
    .err_d    (err_d),
    .locked_d (locked_d),
    .cnt_run  (cnt_run),
    .cnt_wrap (cnt_wrap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      mode_q   <= MODE_PERIODIC;
      len_q    <= LEN_W'(MIN_DELAY);
      strb_q   <= '0;
      err_q    <= 1'b0;
      locked_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      strb_q   <= strb_d;
      err_q    <= err_d;
      locked_q <= locked_d;
      if (start && req_ok) begin
        mode_q <= dlc_mode_e'(mode);
        len_q  <= delay_len;
      end
    end
  end

  always_comb begin
    wr_rst_n = ~strb_q.wr_rst;
    rd_rst_n = ~strb_q.rd_rst;
    wr_en_n  = ~strb_q.wr_en;
    rd_en_n  = ~strb_q.rd_en;
    err      = err_q;
    locked   = locked_q;
  end

endmodule

// File: rtl/dlc_delay_ctrl_chk.sv
module dlc_delay_ctrl_chk #(
  parameter int DEPTH     = 5120,
  parameter int MIN_DELAY = 21,
  parameter int LEN_W     = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [1:0]       mode,
  input logic [LEN_W-1:0] delay_len,
  input logic             wr_rst_n,
  input logic             rd_rst_n,
  input logic             wr_en_n,
  input logic             rd_en_n,
  input logic             err,
  input logic             locked
);
  localparam int CW = LEN_W + 1;

  logic             good;
  logic [1:0]       mode_lat;
  logic [LEN_W-1:0] len_lat;
  logic             valid_lat;
  logic [CW-1:0]    since;

  assign good = (int'(delay_len) >= MIN_DELAY) && (int'(delay_len) <= DEPTH) && (mode != 2'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_lat  <= 2'd0;
      len_lat   <= '0;
      valid_lat <= 1'b0;
      since     <= '0;
    end else if (start) begin
      mode_lat  <= mode;
      len_lat   <= delay_len;
      valid_lat <= good;
      since     <= '0;
    end else if (since != {CW{1'b1}}) begin
      since <= since + CW'(1);
    end
  end

  // R1
  always @(posedge clk) begin
    if (!rst_n) reset_idle_chk: assert (wr_rst_n && rd_rst_n && wr_en_n && rd_en_n && !err && !locked);
  end

  // R2
  reject_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !good) |=> err);

  // R2
  reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (wr_rst_n && rd_rst_n && wr_en_n && rd_en_n && !locked));

  // R3
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_rst_n && !start) |=> wr_rst_n);

  // R3
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_rst_n && !start) |=> rd_rst_n);

  // R6
  hold_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_lat && mode_lat == 2'd2 && !locked && !start) |-> rd_en_n);

  // R7
  lock_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> (since == CW'(len_lat)));

  // R7
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !start) |=> locked);

  // R8
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && good) |=> (!wr_rst_n && !locked && !err));

endmodule

bind dlc_delay_ctrl dlc_delay_ctrl_chk #(
  .DEPTH     (DEPTH),
  .MIN_DELAY (MIN_DELAY),
  .LEN_W     (LEN_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .mode      (mode),
  .delay_len (delay_len),
  .wr_rst_n  (wr_rst_n),
  .rd_rst_n  (rd_rst_n),
  .wr_en_n   (wr_en_n),
  .rd_en_n   (rd_en_n),
  .err       (err),
  .locked    (locked)
);

// File: tb/dlc_delay_ctrl_tb.sv
module dlc_delay_ctrl_tb_top;
  localparam int DEPTH     = 5120;
  localparam int MIN_DELAY = 21;
  localparam int LEN_W     = $clog2(DEPTH + 1);
  localparam int NV        = 11;

  // Vector table: mode, length, expected rejection.
  localparam logic [1:0] V_MODE [NV] = '{2'd0, 2'd1, 2'd2, 2'd0, 2'd1, 2'd2, 2'd0, 2'd1, 2'd3, 2'd0, 2'd2};
  localparam int         V_LEN  [NV] = '{21, 21, 21, 37, 64, 100, 20, 5121, 40, 5120, 5120};
  localparam bit         V_ERR  [NV] = '{0, 0, 0, 0, 0, 0, 1, 1, 1, 0, 0};

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [1:0]       mode = 2'd0;
  logic [LEN_W-1:0] delay_len = '0;
  logic             wr_rst_n, rd_rst_n, wr_en_n, rd_en_n, err, locked;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;

  always #2 clk = ~clk;

  dlc_delay_ctrl #(.DEPTH(DEPTH), .MIN_DELAY(MIN_DELAY)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mode      (mode),
    .delay_len (delay_len),
    .wr_rst_n  (wr_rst_n),
    .rd_rst_n  (rd_rst_n),
    .wr_en_n   (wr_en_n),
    .rd_en_n   (rd_en_n),
    .err       (err),
    .locked    (locked)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp, input int cyc);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s cycle %0d: actual %0d expected %0d", tag, what, cyc, act, exp);
    end
  endtask

  // Drive a start pulse; returns at the negedge of cycle 0.
  task automatic kick(input logic [1:0] m, input int len);
    @(negedge clk);
    start     = 1'b1;
    mode      = m;
    delay_len = LEN_W'(len);
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic idle_cycles(input int k);
    for (int j = 0; j < k; j++) @(negedge clk);
  endtask

  task automatic run_case(input logic [1:0] m, input int len, input bit rej, input string tag);
    int win;
    bit e_wr, e_rd, e_we, e_re, e_lk;
    kick(m, len);
    win = rej ? 40 : 2 * len + 2;
    for (int i = 0; i < win; i++) begin
      if (i != 0) @(negedge clk);
      if (rej) begin
        e_wr = 1; e_rd = 1; e_we = 1; e_re = 1; e_lk = 0;
      end else begin
        e_we = 0;
        e_lk = (i >= len);
        case (m)
          2'd0: begin
            e_wr = (i % len) != 0; e_rd = e_wr; e_re = 0;
          end
          2'd1: begin
            e_wr = (i != 0); e_rd = (i != len); e_re = 0;
          end
          default: begin
            e_wr = (i != 0); e_rd = (i != 0); e_re = (i < len);
          end
        endcase
      end
      chk(err == rej, rej ? "R2" : tag, "err", int'(err), int'(rej), i);
      chk(wr_rst_n == e_wr, rej ? "R2" : "R3", "wr_rst_n", int'(wr_rst_n), int'(e_wr), i);
      chk(rd_rst_n == e_rd, rej ? "R2" : "R3", "rd_rst_n", int'(rd_rst_n), int'(e_rd), i);
      chk(wr_en_n == e_we, rej ? "R2" : tag, "wr_en_n", int'(wr_en_n), int'(e_we), i);
      chk(rd_en_n == e_re, rej ? "R2" : tag, "rd_en_n", int'(rd_en_n), int'(e_re), i);
      chk(locked == e_lk, rej ? "R2" : "R7", "locked", int'(locked), int'(e_lk), i);
    end
  endtask

  function automatic string mode_tag(input logic [1:0] m);
    case (m)
      2'd0:    return "R4";
      2'd1:    return "R5";
      default: return "R6";
    endcase
  endfunction

  initial begin : watchdog
    for (int c = 0; c < 200000; c++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state
    idle_cycles(3);
    chk(wr_rst_n && rd_rst_n, "R1", "reset strobes", int'({wr_rst_n, rd_rst_n}), 3, 0);
    chk(wr_en_n && rd_en_n, "R1", "enables", int'({wr_en_n, rd_en_n}), 3, 0);
    chk(!err && !locked, "R1", "err/locked", int'({err, locked}), 0, 0);
    rst_n = 1'b1;
    idle_cycles(4);
    chk(wr_rst_n && rd_rst_n && wr_en_n && rd_en_n, "R1", "idle after reset",
        int'({wr_rst_n, rd_rst_n, wr_en_n, rd_en_n}), 15, 0);

    for (int v = 0; v < NV; v++)
      run_case(V_MODE[v], V_LEN[v], V_ERR[v], mode_tag(V_MODE[v]));

    // R8: restart mid-sequence with a new mode and length
    kick(2'd0, 30);
    idle_cycles(10);
    run_case(2'd2, 22, 1'b0, "R8");
    kick(2'd1, 40);
    idle_cycles(25);
    run_case(2'd0, 23, 1'b0, "R8");

    // R2: rejected request aborts a running sequence, then valid start clears err
    kick(2'd2, 50);
    idle_cycles(5);
    run_case(2'd1, 10, 1'b1, "R2");
    run_case(2'd1, 21, 1'b0, "R2");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule